// File: doc/BRIEF.md
# Deferred-Load Timer Prescaler

This block divides an incoming clock-enable stream by a programmable ratio and hands the result to a following timer counter as a one-cycle count-enable pulse. An 8-bit down counter steps once per incoming enable. When it underflows, it produces the output pulse and refills itself from a software-written preset. The division ratio is the preset plus one.

A new preset takes effect only at defined points. Software can write the preset register at any time, but the running count is never disturbed. The written value enters the counter only at the next underflow, or when a counter reload is requested. A reload request comes from software or from an external event. It copies the preset into the counter at once, which restarts the division phase in step with the main counter's reload.

Top module: `tmr_prescaler`

## Requirements
- R1: After reset the preset and the counter both hold 00h, so `tick_o` follows `tick_i` (divide by 1) until a different preset is loaded.
- R2: `tick_o` is high only in a cycle where `tick_i` is high and the counter is zero. It is combinational in that same cycle and lasts one cycle per such enable.
- R3: With a steady preset N, `tick_o` pulses on every (N+1)-th `tick_i`. For example, preset 24 gives one pulse per 25 enables.
- R4: With `tick_i` and `reload_i` both low, the counter holds its value. With `tick_i` high, no reload and a nonzero count, it decrements by one.
- R5: A write (`wr_en_i` high, value on `wr_data_i`) updates the preset register on the next clock edge. It does not change a count in progress. The new value is first used at the next underflow load.
- R6: A write in the same cycle as an underflow makes the written value the one loaded at that underflow.
- R7: `reload_i` high loads the preset into the counter on that clock edge, whatever the count. With preset N, the next pulse then comes on the (N+1)-th following enable.
- R8: `reload_i` together with an underflow performs one load from the preset and produces exactly one `tick_o` pulse.
- R9: `reload_i` together with a write loads the written value.
- R10: `reload_i` together with `tick_i` while the count is nonzero loads the preset without decrementing and without a pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Preset register write strobe |
| wr_data_i | input | 8 | Preset value (divide ratio minus one) |
| reload_i | input | 1 | Counter reload request, loads preset immediately |
| tick_i | input | 1 | Input clock-enable to be divided |
| tick_o | output | 1 | Count-enable pulse for the following counter |

## Verification
The counter is hidden, so a wrong internal value shows only as a pulse on `tick_o` in the wrong cycle. That error appears at the first underflow after the fault, which is at most preset-plus-one enables later. A preset register that loads early or late, or a lost or doubled reload, therefore shifts the pulse train within one division period. A behavioural model in the bench tracks the expected count and compares `tick_o` on every cycle. The stimulus is shaped so that writes, reloads and underflows coincide in the ways the requirements single out.

// File: rtl/tmr_prescaler_pkg.sv
package tmr_prescaler_pkg;
  typedef enum logic [1:0] {
    CNT_HOLD = 2'd0,
    CNT_DEC  = 2'd1,
    CNT_LOAD = 2'd2
  } cnt_action_e;
endpackage

// File: rtl/tmr_presc_preset.sv
module tmr_presc_preset #(
  parameter int WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [WIDTH-1:0] wr_data_i,
  output logic [WIDTH-1:0] load_val_o
);
  logic [WIDTH-1:0] preset_q, preset_d;

  always_comb begin
    preset_d = preset_q;
    if (wr_en_i) preset_d = wr_data_i;
  end

  // a same-cycle write is forwarded to any load happening now (R6, R9)
  always_comb load_val_o = wr_en_i ? wr_data_i : preset_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) preset_q <= '0;
    else         preset_q <= preset_d;
  end

  p_write_store_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> preset_q == $past(wr_data_i));
  p_preset_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(preset_q));
endmodule

// File: rtl/tmr_presc_counter.sv
module tmr_presc_counter
  import tmr_prescaler_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             reload_i,
  input  logic [WIDTH-1:0] load_val_i,
  output logic             tick_o
);
  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  logic [WIDTH-1:0] cnt_q, cnt_d;
  logic             at_zero, underflow;
  cnt_action_e      action;

  always_comb begin
    at_zero   = (cnt_q == '0);
    underflow = tick_i && at_zero;
    if (reload_i || underflow) action = CNT_LOAD;
    else if (tick_i)           action = CNT_DEC;
    else                       action = CNT_HOLD;
  end

  always_comb begin
    unique case (action)
      CNT_LOAD: cnt_d = load_val_i;
      CNT_DEC:  cnt_d = cnt_q - ONE;
      default:  cnt_d = cnt_q;
    endcase
  end

  always_comb tick_o = underflow;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  p_reload_load_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reload_i |=> cnt_q == $past(load_val_i));
  p_underflow_load_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> cnt_q == $past(load_val_i));
  p_decrement_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !reload_i && !tick_o) |=> cnt_q == $past(cnt_q) - ONE);
  p_idle_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !reload_i) |=> $stable(cnt_q));
endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [WIDTH-1:0] wr_data_i,
  input  logic             reload_i,
  input  logic             tick_i,
  output logic             tick_o
);
  logic [WIDTH-1:0] load_val;

  tmr_presc_preset #(.WIDTH(WIDTH)) u_preset (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .wr_data_i  (wr_data_i),
    .load_val_o (load_val)
  );

  tmr_presc_counter #(.WIDTH(WIDTH)) u_counter (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick_i),
    .reload_i   (reload_i),
    .load_val_i (load_val),
    .tick_o     (tick_o)
  );

  p_pulse_needs_tick_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |-> tick_i);
endmodule

// File: tb/tmr_prescaler_tb.sv
module tmr_prescaler_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic       reload = 1'b0;
  logic       tick = 1'b0;
  logic       tick_out;

  int checks = 0;
  int fails  = 0;
  int m_cnt  = 0;
  int m_pre  = 0;
  int pulses = 0;
  logic done = 1'b0;

  always #10 clk = ~clk;

  tmr_prescaler #(.WIDTH(8)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .reload_i(reload), .tick_i(tick), .tick_o(tick_out)
  );

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s tick_o actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input string req, input logic w, input int d,
                      input logic rl, input logic tk);
    logic exp;
    int eff;
    @(negedge clk);
    wr_en = w; wr_data = d[7:0]; reload = rl; tick = tk;
    #1;
    exp = tk && (m_cnt == 0);
    check(req, tick_out, exp);
    if (exp) pulses++;
    @(posedge clk);
    eff = w ? d : m_pre;
    if (w) m_pre = d;
    if (rl || exp)  m_cnt = eff;
    else if (tk)    m_cnt = m_cnt - 1;
  endtask

  task automatic count_check(input string req, input int got, input int want);
    checks++;
    if (got != want) begin
      fails++;
      $display("FAIL %s pulse count actual=%0d expected=%0d", req, got, want);
    end
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    // R1: reset state, tick_o follows tick_i while reset is asserted
    @(negedge clk); tick = 1'b1; #1; check("R1", tick_out, 1'b1);
    tick = 1'b0; #1; check("R1", tick_out, 1'b0);
    repeat (2) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    pulses = 0;
    for (int i = 0; i < 6; i++) step("R1", 0, 0, 0, 1);
    count_check("R1", pulses, 6);

    // R3/R4: preset 3 with gaps in tick
    step("R5", 1, 3, 0, 0);
    pulses = 0;
    for (int i = 0; i < 24; i++) step("R3", 0, 0, 0, (i % 3) != 1);
    count_check("R3", pulses, 4);
    for (int i = 0; i < 5; i++) step("R4", 0, 0, 0, 0);

    // R5: write mid-count, old period runs out first
    step("R3", 0, 0, 0, 1);
    step("R5", 1, 7, 0, 0);
    for (int i = 0; i < 20; i++) step("R5", 0, 0, 0, 1);

    // R6: write during an underflow cycle
    while (m_cnt != 0) step("R6", 0, 0, 0, 1);
    step("R6", 1, 5, 0, 1);
    pulses = 0;
    for (int i = 0; i < 12; i++) step("R6", 0, 0, 0, 1);
    count_check("R6", pulses, 2);

    // R7: reload mid-count restarts the period
    step("R7", 0, 0, 0, 1);
    step("R7", 0, 0, 1, 0);
    pulses = 0;
    for (int i = 0; i < 5; i++) step("R7", 0, 0, 0, 1);
    count_check("R7", pulses, 0);
    step("R7", 0, 0, 0, 1);
    count_check("R7", pulses, 1);

    // R8: reload coinciding with underflow
    while (m_cnt != 0) step("R8", 0, 0, 0, 1);
    pulses = 0;
    step("R8", 0, 0, 1, 1);
    count_check("R8", pulses, 1);
    for (int i = 0; i < 6; i++) step("R8", 0, 0, 0, 1);

    // R9: reload with simultaneous write
    step("R9", 1, 2, 1, 0);
    pulses = 0;
    for (int i = 0; i < 9; i++) step("R9", 0, 0, 0, 1);
    count_check("R9", pulses, 3);

    // R10: reload with tick on nonzero count
    step("R10", 0, 0, 0, 1);
    step("R10", 0, 0, 1, 1);
    step("R10", 1, 0, 1, 1);
    for (int i = 0; i < 4; i++) step("R10", 0, 0, 0, 1);

    // R2: pseudo-random mixed traffic against the model
    lfsr = 16'hACE1;
    for (int i = 0; i < 3000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step("R2", lfsr[3:0] == 4'h0, {28'd0, lfsr[7:4]}, lfsr[11:8] == 4'h5, lfsr[0] | lfsr[1]);
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule